// File: doc/BRIEF.md
# Byte-Wide Multi-Cycle Processor Core

This block is a small processor with an 8-bit datapath. It has four general registers, a 16-bit program counter, and a zero flag and a carry flag. It reads its program one byte at a time from a synchronous memory port. The memory returns the addressed byte on the cycle after the address is presented.

Every instruction is an opcode byte followed by two operand bytes, except halt, which is one byte. The core supports:
- register moves, from an immediate or from a register;
- add and subtract;
- compare, against an immediate or a register;
- an unconditional jump and two jumps that test the zero flag;
- halt.

The core never writes to memory. It stops on halt or on an undefined opcode. An undefined opcode also raises a sticky error output.

The carry flag holds the carry-out of add and the borrow of subtract and compare. No instruction reads it, so it cannot be seen at the ports. Only the zero flag steers program flow.

Top module: `byte_cpu`

## Requirements
- R1: While reset is asserted, mem_addr is 0x0000 and halted and illegal are 0. Reset clears all four registers and both flags. The first opcode fetch after reset is from 0x0000.
- R2: Each byte fetch takes two cycles with mem_addr held constant: a request cycle, then a capture cycle in which mem_rdata is taken. The program counter moves past the opcode and past each operand byte as it is captured. A three-byte instruction therefore presents pc, pc, pc+1, pc+1, pc+2, pc+2, and then the next instruction's opcode address.
- R3: A register operand value 0, 1, 2 or 3 selects A, B, C or D. A register operand of any other value reads as 0, and a write to it changes no register.
- R4: MOV with immediate (opcode 0x01, bytes: dest, imm) and MOV from register (opcode 0x08, bytes: dest, src) write the value to dest. They set zero when the value is 0 and clear it otherwise, and leave carry unchanged.
- R5: ADD (opcode 0x02, bytes: r1, r2) writes the 8-bit sum r1+r2 to r1 and sets zero from that sum.
- R6: SUB (opcode 0x03, bytes: r1, r2) writes the 8-bit difference r1-r2 to r1 and sets zero from that difference.
- R7: CMP with immediate (opcode 0x07, bytes: r1, imm) and CMP with register (opcode 0x09, bytes: r1, r2) set zero when the 8-bit difference is 0. They write no register.
- R8: JMP (opcode 0x04) takes a 16-bit target whose low byte is the first operand and whose high byte is the second. The next opcode is fetched from that target.
- R9: JZ (0x05) jumps only when zero is set, and JNZ (0x06) jumps only when zero is clear. Jumps leave both flags unchanged. A jump that is not taken still reads both target bytes and continues at the following instruction.
- R10: HLT (0xFF) takes two cycles. halted then rises and stays high, and mem_addr stays at the halt address plus one. No register changes after that.
- R11: An opcode outside 0x01..0x09 and 0xFF stops the core the same way as HLT, and also raises illegal. Illegal stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 16 | Program byte address (equals the program counter) |
| mem_rdata | input | 8 | Byte returned by memory one cycle after its address |
| halted | output | 1 | Core has stopped |
| illegal | output | 1 | Sticky: stopped on an undefined opcode |

## Verification
The bench builds the core with its default reset address of 0x0000, so the reset check and every program start from the first memory byte. Register contents and the zero flag are not ports, so the bench observes them through the cycle-exact trace of fetch addresses. After each compare, move or arithmetic step it places a conditional jump, and the jump target reveals the flag. Random programs use register indices up to 4, immediates biased to 0 and 255, and jump targets anywhere in the program. Together these reach out-of-range register reads and writes, wrap-around in add and subtract, and both outcomes of each conditional jump.

// File: rtl/byte_cpu.sv
module byte_cpu #(
  parameter logic [15:0] RESET_PC = 16'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] mem_addr,
  input  logic [7:0]  mem_rdata,
  output logic        halted,
  output logic        illegal
);
  localparam logic [7:0] OP_MOVI = 8'h01;
  localparam logic [7:0] OP_ADD  = 8'h02;
  localparam logic [7:0] OP_SUB  = 8'h03;
  localparam logic [7:0] OP_JMP  = 8'h04;
  localparam logic [7:0] OP_JZ   = 8'h05;
  localparam logic [7:0] OP_JNZ  = 8'h06;
  localparam logic [7:0] OP_CMPI = 8'h07;
  localparam logic [7:0] OP_MOVR = 8'h08;
  localparam logic [7:0] OP_CMPR = 8'h09;
  localparam logic [7:0] OP_HLT  = 8'hFF;

  typedef enum logic [2:0] {
    S_OREQ, S_OCAP, S_AREQ, S_ACAP, S_BREQ, S_BCAP, S_HALT
  } state_t;

  state_t          state;
  logic [15:0]     pc;
  logic [7:0]      op, opa;
  logic [3:0][7:0] rf;
  logic            zf, cf, ill;

  logic [7:0]  ra, rb, bsel;
  logic [8:0]  sum, dif;
  logic [15:0] target;
  logic        op_known, use_imm;

  assign mem_addr = pc;
  assign halted   = (state == S_HALT);
  assign illegal  = ill;

  assign ra       = (opa < 8'd4) ? rf[opa[1:0]] : 8'd0;
  assign rb       = (mem_rdata < 8'd4) ? rf[mem_rdata[1:0]] : 8'd0;
  assign use_imm  = (op == OP_MOVI) || (op == OP_CMPI);
  assign bsel     = use_imm ? mem_rdata : rb;
  assign sum      = {1'b0, ra} + {1'b0, bsel};
  assign dif      = {1'b0, ra} - {1'b0, bsel};
  assign target   = {mem_rdata, opa};
  assign op_known = (mem_rdata >= OP_MOVI && mem_rdata <= OP_CMPR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_OREQ;
      pc    <= RESET_PC;
      op    <= 8'd0;
      opa   <= 8'd0;
      rf    <= '0;
      zf    <= 1'b0;
      cf    <= 1'b0;
      ill   <= 1'b0;
    end else begin
      case (state)
        S_OREQ: state <= S_OCAP;
        S_OCAP: begin
          op <= mem_rdata;
          pc <= pc + 16'd1;
          if (mem_rdata == OP_HLT) begin
            state <= S_HALT;
          end else if (!op_known) begin
            ill   <= 1'b1;
            state <= S_HALT;
          end else begin
            state <= S_AREQ;
          end
        end
        S_AREQ: state <= S_ACAP;
        S_ACAP: begin
          opa   <= mem_rdata;
          pc    <= pc + 16'd1;
          state <= S_BREQ;
        end
        S_BREQ: state <= S_BCAP;
        S_BCAP: begin
          state <= S_OREQ;
          pc    <= pc + 16'd1;
          case (op)
            OP_MOVI, OP_MOVR: begin
              if (opa < 8'd4) rf[opa[1:0]] <= bsel;
              zf <= (bsel == 8'd0);
            end
            OP_ADD: begin
              if (opa < 8'd4) rf[opa[1:0]] <= sum[7:0];
              zf <= (sum[7:0] == 8'd0);
              cf <= sum[8];
            end
            OP_SUB: begin
              if (opa < 8'd4) rf[opa[1:0]] <= dif[7:0];
              zf <= (dif[7:0] == 8'd0);
              cf <= dif[8];
            end
            OP_CMPI, OP_CMPR: begin
              zf <= (dif[7:0] == 8'd0);
              cf <= dif[8];
            end
            OP_JMP: pc <= target;
            OP_JZ:  if (zf)  pc <= target;
            OP_JNZ: if (!zf) pc <= target;
            default: ;
          endcase
        end
        S_HALT: ;
        default: state <= S_HALT;
      endcase
    end
  end

  p_fetch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_OREQ || state == S_AREQ || state == S_BREQ) |=> $stable(mem_addr));

  p_operand_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ACAP) |=> (mem_addr == $past(mem_addr) + 16'd1));

  p_cmp_nowrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BCAP && (op == OP_CMPI || op == OP_CMPR)) |=> $stable(rf));

  p_jump_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BCAP && (op == OP_JMP || op == OP_JZ || op == OP_JNZ)) |=> ($stable(zf) && $stable(cf)));

  p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  p_halt_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> ($stable(rf) && $stable(mem_addr)));

  p_ill_halts_r11: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> halted);

  p_ill_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> illegal);
endmodule

// File: tb/sim_byte_cpu.sv
module sim_byte_cpu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = 8'd0;
  logic        halted, illegal;

  always #10 clk = ~clk;

  byte_cpu u0 (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .halted(halted), .illegal(illegal)
  );

  logic [7:0] mem [0:1023];
  always @(posedge clk) mem_rdata <= mem[mem_addr[9:0]];

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int wp;

  logic [15:0] m_pc;
  logic [7:0]  m_rf [0:3];
  logic        m_z, m_c, m_halt, m_ill;
  logic [17:0] q [$];

  function automatic logic [7:0] m_rd(input logic [7:0] idx);
    return (idx < 8'd4) ? m_rf[idx[1:0]] : 8'd0;
  endfunction

  task automatic m_wr(input logic [7:0] idx, input logic [7:0] v);
    if (idx < 8'd4) m_rf[idx[1:0]] = v;
  endtask

  task automatic push2(input logic [15:0] a);
    q.push_back({a, 2'b00});
    q.push_back({a, 2'b00});
  endtask

  task automatic m_step();
    logic [7:0] op, a, b, v;
    logic [8:0] r;
    op = mem[m_pc[9:0]]; push2(m_pc); m_pc = m_pc + 16'd1;
    if (op == 8'hFF) begin m_halt = 1'b1; return; end
    if (op == 8'h00 || (op > 8'h09)) begin m_halt = 1'b1; m_ill = 1'b1; return; end
    a = mem[m_pc[9:0]]; push2(m_pc); m_pc = m_pc + 16'd1;
    b = mem[m_pc[9:0]]; push2(m_pc); m_pc = m_pc + 16'd1;
    case (op)
      8'h01, 8'h08: begin v = (op == 8'h01) ? b : m_rd(b); m_wr(a, v); m_z = (v == 8'd0); end
      8'h02: begin r = {1'b0, m_rd(a)} + {1'b0, m_rd(b)}; m_wr(a, r[7:0]); m_z = (r[7:0] == 0); m_c = r[8]; end
      8'h03: begin r = {1'b0, m_rd(a)} - {1'b0, m_rd(b)}; m_wr(a, r[7:0]); m_z = (r[7:0] == 0); m_c = r[8]; end
      8'h07, 8'h09: begin
        v = (op == 8'h07) ? b : m_rd(b);
        r = {1'b0, m_rd(a)} - {1'b0, v}; m_z = (r[7:0] == 0); m_c = r[8];
      end
      8'h04: m_pc = {b, a};
      8'h05: if (m_z) m_pc = {b, a};
      8'h06: if (!m_z) m_pc = {b, a};
      default: ;
    endcase
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    wp = 0;
  endtask

  task automatic e3(input logic [7:0] op, input logic [7:0] a, input logic [7:0] b);
    mem[wp] = op; mem[wp+1] = a; mem[wp+2] = b; wp = wp + 3;
  endtask

  task automatic e1(input logic [7:0] op);
    mem[wp] = op; wp = wp + 1;
  endtask

  task automatic run_prog(input string tag, input int ncyc);
    logic [17:0] e;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    n_cmp++;
    if (mem_addr !== 16'h0000 || halted !== 1'b0 || illegal !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset state: addr=%h h=%b i=%b expected addr=0000 h=0 i=0", mem_addr, halted, illegal);
    end
    @(negedge clk);
    rst_n = 1'b1;
    m_pc = 16'h0000; m_z = 0; m_c = 0; m_halt = 0; m_ill = 0;
    for (int i = 0; i < 4; i++) m_rf[i] = 8'd0;
    q.delete();
    for (int c = 0; c < ncyc; c++) begin
      if (q.size() == 0) begin
        if (m_halt) q.push_back({m_pc, 1'b1, m_ill});
        else m_step();
      end
      e = q.pop_front();
      #1;
      n_cmp++;
      if ({mem_addr, halted, illegal} !== e) begin
        n_bad++;
        $display("FAIL %s cycle %0d: addr=%h h=%b i=%b expected addr=%h h=%b i=%b",
                 tag, c, mem_addr, halted, illegal, e[17:2], e[1], e[0]);
      end
      @(negedge clk);
    end
  endtask

  function automatic logic [7:0] pick_imm();
    case ($urandom % 4)
      0: return 8'd0;
      1: return 8'd255;
      2: return 8'($urandom % 4);
      default: return 8'($urandom);
    endcase
  endfunction

  task automatic gen_random();
    int n;
    logic [7:0] ops [0:11];
    logic [7:0] op;
    logic [15:0] t;
    ops = '{8'h01, 8'h08, 8'h02, 8'h03, 8'h07, 8'h09, 8'h05, 8'h06, 8'h05, 8'h06, 8'h07, 8'h04};
    clear_mem();
    n = 16;
    for (int i = 0; i < 4; i++) e3(8'h01, 8'(i), pick_imm());
    for (int k = 0; k < n; k++) begin
      op = ops[$urandom % 12];
      if (op == 8'h04 && ($urandom % 2) == 0) op = 8'h07;
      if (op == 8'h04 || op == 8'h05 || op == 8'h06) begin
        t = 16'(12 + 3 * ($urandom % (n + 1)));
        e3(op, t[7:0], t[15:8]);
      end else if (op == 8'h01 || op == 8'h07) begin
        e3(op, 8'($urandom % 5), pick_imm());
      end else begin
        e3(op, 8'($urandom % 5), 8'($urandom % 5));
      end
    end
    e1(8'hFF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));

    // R10: halt at the first byte
    clear_mem(); e1(8'hFF);
    run_prog("R10 halt", 12);

    // R4 / R9: move sets zero, conditional jumps on both outcomes
    clear_mem();
    e3(8'h01, 8'd0, 8'd0);      // 0: mov a,0 -> Z=1
    e3(8'h05, 8'd9, 8'd0);      // 3: jz 9 (taken)
    e1(8'h0B);                  // 6: illegal if wrong path
    wp = 9;
    e3(8'h01, 8'd1, 8'd7);      // 9: mov b,7 -> Z=0
    e3(8'h05, 8'd6, 8'd0);      // 12: jz 6 (not taken)
    e3(8'h08, 8'd2, 8'd1);      // 15: mov c,b -> Z=0
    e3(8'h06, 8'd24, 8'd0);     // 18: jnz 24 (taken)
    e1(8'hFF);
    wp = 24;
    e3(8'h08, 8'd3, 8'd0);      // mov d,a -> 0, Z=1
    e3(8'h06, 8'd6, 8'd0);      // jnz not taken
    e1(8'hFF);
    run_prog("R4 R9 move/branch", 80);

    // R3: out-of-range register index
    clear_mem();
    e3(8'h01, 8'd0, 8'd5);      // mov a,5
    e3(8'h01, 8'd4, 8'd9);      // mov [4],9 ignored, Z=0
    e3(8'h07, 8'd0, 8'd5);      // cmp a,5 -> Z=1
    e3(8'h06, 8'd60, 8'd0);     // jnz away if wrong
    e3(8'h08, 8'd1, 8'd6);      // mov b,[6] -> 0, Z=1
    e3(8'h06, 8'd60, 8'd0);
    e3(8'h07, 8'd7, 8'd0);      // cmp [7],0 -> Z=1
    e3(8'h06, 8'd60, 8'd0);
    e3(8'h09, 8'd1, 8'd5);      // cmp b,[5] -> Z=1
    e3(8'h06, 8'd60, 8'd0);
    e1(8'hFF);
    run_prog("R3 register index", 90);

    // R5: add with wrap to zero
    clear_mem();
    e3(8'h01, 8'd0, 8'd200);
    e3(8'h01, 8'd1, 8'd56);
    e3(8'h02, 8'd0, 8'd1);      // a = 0, Z=1
    e3(8'h06, 8'd60, 8'd0);
    e3(8'h02, 8'd1, 8'd1);      // b = 112, Z=0
    e3(8'h07, 8'd1, 8'd112);
    e3(8'h06, 8'd60, 8'd0);
    e1(8'hFF);
    run_prog("R5 add", 70);

    // R6: subtract to zero then borrow
    clear_mem();
    e3(8'h01, 8'd0, 8'd3);
    e3(8'h01, 8'd1, 8'd3);
    e3(8'h03, 8'd0, 8'd1);      // a = 0
    e3(8'h06, 8'd60, 8'd0);
    e3(8'h03, 8'd0, 8'd1);      // a = 253
    e3(8'h05, 8'd60, 8'd0);
    e3(8'h07, 8'd0, 8'd253);
    e3(8'h06, 8'd60, 8'd0);
    e1(8'hFF);
    run_prog("R6 sub", 80);

    // R7: compare leaves registers unchanged
    clear_mem();
    e3(8'h01, 8'd0, 8'd9);
    e3(8'h07, 8'd0, 8'd9);
    e3(8'h06, 8'd60, 8'd0);
    e3(8'h07, 8'd0, 8'd9);
    e3(8'h06, 8'd60, 8'd0);
    e3(8'h01, 8'd2, 8'd10);
    e3(8'h09, 8'd0, 8'd2);      // 9-10 -> Z=0
    e3(8'h05, 8'd60, 8'd0);
    e3(8'h09, 8'd2, 8'd2);
    e3(8'h06, 8'd60, 8'd0);
    e1(8'hFF);
    run_prog("R7 compare", 90);

    // R8: jump target byte order
    clear_mem();
    e3(8'h04, 8'h23, 8'h01);
    e1(8'hFF);
    wp = 16'h0123;
    e3(8'h01, 8'd0, 8'd1);
    e1(8'hFF);
    run_prog("R8 jump", 30);

    // R11: undefined opcode after a move
    clear_mem();
    e3(8'h01, 8'd0, 8'd1);
    e1(8'h0A);
    e3(8'h01, 8'd1, 8'd1);
    run_prog("R11 illegal", 20);

    // R2 with random programs covering R3..R9
    for (int p = 0; p < 30; p++) begin
      gen_random();
      run_prog("R2 random", 500);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule